// File: doc/BRIEF.md
# Multicast Copy and Enqueue Engine

The engine sits between the arrival of a shim descriptor and the queue managers. Each descriptor carries a buffer handle, a frame length, a slice number, a result index and a stats index. The engine reads the addressed result-table entry through a one-cycle memory read port. It checks the slice's packet budget in an internal limit table. It then issues either one queue request (unicast) or a burst of copies (multicast).

For multicast, every copy pairs a fresh header buffer, taken from an external allocator, with the shared payload buffer. The engine writes the copy count into the payload's reference count. A refused or empty packet has its buffer handed to a free port. The engine accepts a new descriptor only after the current one has been fully handled.

The limit table is loaded through a configuration write and observed through a monitor read. Header rewriting and buffer allocation stay outside the block.

Top module: `mcast_copy_engine`

## Requirements
- R1: After reset, inReady is 1, no qmValid, refValid or freeValid is raised, and every slice reads current 0 and over-limit 0.
- R2: The top bit of inResultIdx is the type flag, 1 for multicast. The low IDX_W bits are the table index, driven on rtAddr with rtRd high in the cycle of acceptance.
- R3: A result word holds the fanout in bits [23:20] and the queue ID in bits [19:0]. Queue ID bits [19:18] pick the queue manager and bits [17:0] go out on qmQueue. An accepted unicast raises exactly that port's qmValid two cycles after acceptance, carrying the buffer handle, frame length and stats index, with qmChained 0.
- R4: A packet is accepted only while the slice's current count is below its maximum. Acceptance increments the current count by one.
- R5: A refused packet (unicast or multicast) has its buffer handle put out on the free port. Its over-limit count increments and its current count is unchanged.
- R6: An accepted multicast with nonzero fanout and nonzero frame length first raises refValid. refHandle is the payload handle and refCount is the fanout.
- R7: Multicast copy k (1..fanout) uses the queue ID from table entry index+k, with one copy per cycle. Each copy carries the next allocator header handle on qmHandle and the payload handle on qmPayload, and it pulses hdrTake.
- R8: An accepted multicast with frame length 0 frees the payload buffer instead of writing a reference count. Its copies carry qmChained 0, while copies of a non-empty payload carry qmChained 1.
- R9: A multicast entry with fanout 0 frees the buffer and leaves the current and over-limit counts unchanged.
- R10: inReady is low from the cycle after acceptance until the last output of that descriptor has been issued, so no descriptor is taken during a copy burst.
- R11: A configuration write sets the slice's maximum and clears its current and over-limit counts.
- R12: A fanout of 15 produces 15 copies, read from entries index+1 through index+15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Descriptor present |
| inReady | output | 1 | Engine idle, descriptor taken when inValid is high |
| inHandle | input | HANDLE_W | Packet (payload) buffer handle |
| inLen | input | LEN_W | Frame length |
| inSlice | input | SLICE_W | Slice number |
| inResultIdx | input | IDX_W+1 | Type flag and result-table index |
| inStats | input | STATS_W | Stats index |
| rtRd | output | 1 | Result-table read strobe |
| rtAddr | output | IDX_W | Result-table read address |
| rtData | input | 24 | Read word, valid the cycle after rtRd |
| hdrHandle | input | HANDLE_W | Next free header buffer from the allocator |
| hdrTake | output | 1 | Consumes hdrHandle |
| qmValid | output | NUM_QM | One-hot request strobe per queue manager |
| qmHandle | output | HANDLE_W | Enqueued (header or unicast) buffer |
| qmPayload | output | HANDLE_W | Payload buffer of a copy |
| qmChained | output | 1 | Header is chained to a payload |
| qmQueue | output | QID_W-QM_W | Scheduler and per-scheduler queue number |
| qmLen | output | LEN_W | Frame length |
| qmStats | output | STATS_W | Stats index |
| refValid | output | 1 | Reference-count write strobe |
| refHandle | output | HANDLE_W | Payload buffer written |
| refCount | output | FAN_W | Reference count value |
| freeValid | output | 1 | Buffer release strobe |
| freeHandle | output | HANDLE_W | Released buffer |
| cfgWr | input | 1 | Limit configuration write |
| cfgSlice | input | SLICE_W | Slice configured |
| cfgMax | input | CNT_W | New maximum |
| monSlice | input | SLICE_W | Slice observed |
| monCur | output | CNT_W | Current count of monSlice |
| monOver | output | CNT_W | Over-limit count of monSlice |

## Verification
The bench builds the engine with SLICE_W of 4 and IDX_W of 6. With 16 slices, every slice's counters can be configured and read back. The 64-entry result table holds a full fanout-15 burst next to unicast and zero-fanout entries. Budgets of 0, 2 and 10 drive the limit check to both sides of its edge, and the default queue-ID and fanout widths keep all four queue-manager ports and the largest copy count in play.

// File: rtl/copy_pkg.sv
package copy_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_COPY} engState_t;

  typedef struct packed {
    logic capture;
    logic rdEntry;
    logic rdCopy;
    logic latchEntry;
    logic enqUni;
    logic enqCopy;
    logic dropBuf;
    logic setRef;
    logic limInc;
    logic overInc;
  } ctrlStrobe_t;

  typedef struct packed {
    logic isMcast;
    logic fanZero;
    logic underLimit;
    logic lenZero;
    logic lastCopy;
  } dpStatus_t;
endpackage

// File: rtl/copy_limit_table.sv
module copy_limit_table #(
  parameter int SLICE_W = 11,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SLICE_W-1:0] slice,
  output logic               underLimit,
  input  logic               limInc,
  input  logic               overInc,
  input  logic               cfgWr,
  input  logic [SLICE_W-1:0] cfgSlice,
  input  logic [CNT_W-1:0]   cfgMax,
  input  logic [SLICE_W-1:0] monSlice,
  output logic [CNT_W-1:0]   monCur,
  output logic [CNT_W-1:0]   monOver
);
  localparam int NUM_SLICES = 1 << SLICE_W;

  logic [CNT_W-1:0] curCnt  [NUM_SLICES];
  logic [CNT_W-1:0] maxCnt  [NUM_SLICES];
  logic [CNT_W-1:0] overCnt [NUM_SLICES];

  assign underLimit = curCnt[slice] < maxCnt[slice];
  assign monCur     = curCnt[monSlice];
  assign monOver    = overCnt[monSlice];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLICES; i++) begin
        curCnt[i]  <= '0;
        maxCnt[i]  <= '0;
        overCnt[i] <= '0;
      end
    end else begin
      if (limInc)  curCnt[slice]  <= curCnt[slice] + 1'b1;
      if (overInc) overCnt[slice] <= overCnt[slice] + 1'b1;
      if (cfgWr) begin
        maxCnt[cfgSlice]  <= cfgMax;
        curCnt[cfgSlice]  <= '0;
        overCnt[cfgSlice] <= '0;
      end
    end
  end
endmodule

// File: rtl/copy_ctrl.sv
module copy_ctrl
  import copy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);
  engState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    inReady   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.capture = 1'b1;
          strobe.rdEntry = 1'b1;
          stateNext      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strobe.latchEntry = 1'b1;
        stateNext         = ST_IDLE;
        if (!status.isMcast) begin
          if (status.underLimit) begin
            strobe.limInc = 1'b1;
            strobe.enqUni = 1'b1;
          end else begin
            strobe.overInc = 1'b1;
            strobe.dropBuf = 1'b1;
          end
        end else if (status.fanZero) begin
          strobe.dropBuf = 1'b1;
        end else if (!status.underLimit) begin
          strobe.overInc = 1'b1;
          strobe.dropBuf = 1'b1;
        end else begin
          strobe.limInc  = 1'b1;
          strobe.dropBuf = status.lenZero;
          strobe.setRef  = !status.lenZero;
          strobe.rdCopy  = 1'b1;
          stateNext      = ST_COPY;
        end
      end
      ST_COPY: begin
        strobe.enqCopy = 1'b1;
        if (status.lastCopy) stateNext = ST_IDLE;
        else                 strobe.rdCopy = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/copy_datapath.sv
module copy_datapath
  import copy_pkg::*;
#(
  parameter int HANDLE_W = 24,
  parameter int LEN_W    = 16,
  parameter int SLICE_W  = 11,
  parameter int IDX_W    = 18,
  parameter int STATS_W  = 16,
  parameter int CNT_W    = 16,
  parameter int FAN_W    = 4,
  parameter int QM_W     = 2,
  parameter int QID_W    = 20,
  localparam int NUM_QM  = 1 << QM_W,
  localparam int RT_W    = FAN_W + QID_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  output dpStatus_t           status,
  input  logic [HANDLE_W-1:0] inHandle,
  input  logic [LEN_W-1:0]    inLen,
  input  logic [SLICE_W-1:0]  inSlice,
  input  logic [IDX_W:0]      inResultIdx,
  input  logic [STATS_W-1:0]  inStats,
  output logic                rtRd,
  output logic [IDX_W-1:0]    rtAddr,
  input  logic [RT_W-1:0]     rtData,
  input  logic [HANDLE_W-1:0] hdrHandle,
  output logic                hdrTake,
  output logic [NUM_QM-1:0]   qmValid,
  output logic [HANDLE_W-1:0] qmHandle,
  output logic [HANDLE_W-1:0] qmPayload,
  output logic                qmChained,
  output logic [QID_W-QM_W-1:0] qmQueue,
  output logic [LEN_W-1:0]    qmLen,
  output logic [STATS_W-1:0]  qmStats,
  output logic                refValid,
  output logic [HANDLE_W-1:0] refHandle,
  output logic [FAN_W-1:0]    refCount,
  output logic                freeValid,
  output logic [HANDLE_W-1:0] freeHandle,
  input  logic                cfgWr,
  input  logic [SLICE_W-1:0]  cfgSlice,
  input  logic [CNT_W-1:0]    cfgMax,
  input  logic [SLICE_W-1:0]  monSlice,
  output logic [CNT_W-1:0]    monCur,
  output logic [CNT_W-1:0]    monOver
);
  logic [HANDLE_W-1:0] bufQ;
  logic [LEN_W-1:0]    lenQ;
  logic [SLICE_W-1:0]  sliceQ;
  logic [IDX_W-1:0]    idxQ;
  logic [STATS_W-1:0]  statsQ;
  logic                mcastQ;
  logic [FAN_W-1:0]    fanQ;
  logic [FAN_W-1:0]    copyNum;
  logic                underLimit;

  logic [FAN_W-1:0]  entFan;
  logic [QM_W-1:0]   entQm;
  logic [QID_W-QM_W-1:0] entQueue;

  assign entFan   = rtData[RT_W-1 -: FAN_W];
  assign entQm    = rtData[QID_W-1 -: QM_W];
  assign entQueue = rtData[QID_W-QM_W-1:0];

  copy_limit_table #(.SLICE_W(SLICE_W), .CNT_W(CNT_W)) u_limits (
    .clk(clk), .rstN(rstN), .slice(sliceQ), .underLimit(underLimit),
    .limInc(strobe.limInc), .overInc(strobe.overInc),
    .cfgWr(cfgWr), .cfgSlice(cfgSlice), .cfgMax(cfgMax),
    .monSlice(monSlice), .monCur(monCur), .monOver(monOver)
  );

  assign status.isMcast    = mcastQ;
  assign status.fanZero    = (entFan == '0);
  assign status.underLimit = underLimit;
  assign status.lenZero    = (lenQ == '0);
  assign status.lastCopy   = (copyNum == fanQ);

  assign rtRd    = strobe.rdEntry | strobe.rdCopy;
  assign rtAddr  = strobe.rdEntry ? inResultIdx[IDX_W-1:0]
                                  : idxQ + IDX_W'(copyNum) + 1'b1;
  assign hdrTake = strobe.enqCopy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0; lenQ <= '0; sliceQ <= '0; idxQ <= '0;
      statsQ <= '0; mcastQ <= 1'b0; fanQ <= '0; copyNum <= '0;
    end else begin
      if (strobe.capture) begin
        bufQ    <= inHandle;
        lenQ    <= inLen;
        sliceQ  <= inSlice;
        idxQ    <= inResultIdx[IDX_W-1:0];
        mcastQ  <= inResultIdx[IDX_W];
        statsQ  <= inStats;
        copyNum <= '0;
      end
      if (strobe.latchEntry) fanQ <= entFan;
      if (strobe.rdCopy)     copyNum <= copyNum + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qmValid <= '0; qmHandle <= '0; qmPayload <= '0; qmChained <= 1'b0;
      qmQueue <= '0; qmLen <= '0; qmStats <= '0;
      refValid <= 1'b0; refHandle <= '0; refCount <= '0;
      freeValid <= 1'b0; freeHandle <= '0;
    end else begin
      qmValid   <= '0;
      refValid  <= strobe.setRef;
      freeValid <= strobe.dropBuf;
      if (strobe.enqUni || strobe.enqCopy) begin
        qmValid[entQm] <= 1'b1;
        qmQueue   <= entQueue;
        qmLen     <= lenQ;
        qmStats   <= statsQ;
        qmHandle  <= strobe.enqCopy ? hdrHandle : bufQ;
        qmPayload <= strobe.enqCopy ? bufQ : '0;
        qmChained <= strobe.enqCopy && (lenQ != '0);
      end
      if (strobe.setRef) begin
        refHandle <= bufQ;
        refCount  <= entFan;
      end
      if (strobe.dropBuf) freeHandle <= bufQ;
    end
  end
endmodule

// File: rtl/mcast_copy_engine.sv
module mcast_copy_engine
  import copy_pkg::*;
#(
  parameter int HANDLE_W = 24,
  parameter int LEN_W    = 16,
  parameter int SLICE_W  = 11,
  parameter int IDX_W    = 18,
  parameter int STATS_W  = 16,
  parameter int CNT_W    = 16,
  parameter int FAN_W    = 4,
  parameter int QM_W     = 2,
  parameter int SCHED_W  = 3,
  parameter int QNUM_W   = 15,
  localparam int QID_W   = QM_W + SCHED_W + QNUM_W,
  localparam int NUM_QM  = 1 << QM_W,
  localparam int RT_W    = FAN_W + QID_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [HANDLE_W-1:0] inHandle,
  input  logic [LEN_W-1:0]    inLen,
  input  logic [SLICE_W-1:0]  inSlice,
  input  logic [IDX_W:0]      inResultIdx,
  input  logic [STATS_W-1:0]  inStats,
  output logic                rtRd,
  output logic [IDX_W-1:0]    rtAddr,
  input  logic [RT_W-1:0]     rtData,
  input  logic [HANDLE_W-1:0] hdrHandle,
  output logic                hdrTake,
  output logic [NUM_QM-1:0]   qmValid,
  output logic [HANDLE_W-1:0] qmHandle,
  output logic [HANDLE_W-1:0] qmPayload,
  output logic                qmChained,
  output logic [QID_W-QM_W-1:0] qmQueue,
  output logic [LEN_W-1:0]    qmLen,
  output logic [STATS_W-1:0]  qmStats,
  output logic                refValid,
  output logic [HANDLE_W-1:0] refHandle,
  output logic [FAN_W-1:0]    refCount,
  output logic                freeValid,
  output logic [HANDLE_W-1:0] freeHandle,
  input  logic                cfgWr,
  input  logic [SLICE_W-1:0]  cfgSlice,
  input  logic [CNT_W-1:0]    cfgMax,
  input  logic [SLICE_W-1:0]  monSlice,
  output logic [CNT_W-1:0]    monCur,
  output logic [CNT_W-1:0]    monOver
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  copy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .status(status), .strobe(strobe)
  );

  copy_datapath #(
    .HANDLE_W(HANDLE_W), .LEN_W(LEN_W), .SLICE_W(SLICE_W), .IDX_W(IDX_W),
    .STATS_W(STATS_W), .CNT_W(CNT_W), .FAN_W(FAN_W), .QM_W(QM_W), .QID_W(QID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .inHandle(inHandle), .inLen(inLen), .inSlice(inSlice),
    .inResultIdx(inResultIdx), .inStats(inStats),
    .rtRd(rtRd), .rtAddr(rtAddr), .rtData(rtData),
    .hdrHandle(hdrHandle), .hdrTake(hdrTake),
    .qmValid(qmValid), .qmHandle(qmHandle), .qmPayload(qmPayload),
    .qmChained(qmChained), .qmQueue(qmQueue), .qmLen(qmLen), .qmStats(qmStats),
    .refValid(refValid), .refHandle(refHandle), .refCount(refCount),
    .freeValid(freeValid), .freeHandle(freeHandle),
    .cfgWr(cfgWr), .cfgSlice(cfgSlice), .cfgMax(cfgMax),
    .monSlice(monSlice), .monCur(monCur), .monOver(monOver)
  );
endmodule

// File: rtl/copy_engine_chk.sv
module copy_engine_chk #(
  parameter int NUM_QM = 4,
  parameter int FAN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              hdrTake,
  input logic [NUM_QM-1:0] qmValid,
  input logic              refValid,
  input logic [FAN_W-1:0]  refCount,
  input logic              freeValid
);
  // R3
  qm_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(qmValid));

  // R10
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R10
  copy_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrTake |-> !inReady);

  // R6
  ref_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> (refCount != '0));

  // R7
  copy_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrTake |=> (|qmValid));

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({|qmValid, refValid, freeValid}) <= 1);
endmodule

bind mcast_copy_engine copy_engine_chk #(.NUM_QM(NUM_QM), .FAN_W(FAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .hdrTake(hdrTake), .qmValid(qmValid), .refValid(refValid),
  .refCount(refCount), .freeValid(freeValid)
);

// File: tb/tb_mcast_copy_engine.sv
module tb_mcast_copy_engine;
  localparam int HW = 24, LW = 16, SW = 4, IW = 6, STW = 16, CW = 16, FW = 4;
  localparam int QMW = 2, QIDW = 20, NQ = 4, RTW = 24;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic inValid = 0, inReady;
  logic [HW-1:0] inHandle = '0;
  logic [LW-1:0] inLen = '0;
  logic [SW-1:0] inSlice = '0;
  logic [IW:0]   inResultIdx = '0;
  logic [STW-1:0] inStats = '0;
  logic rtRd; logic [IW-1:0] rtAddr; logic [RTW-1:0] rtData = '0;
  logic [HW-1:0] hdrHandle = 24'h100; logic hdrTake;
  logic [NQ-1:0] qmValid; logic [HW-1:0] qmHandle, qmPayload; logic qmChained;
  logic [QIDW-QMW-1:0] qmQueue; logic [LW-1:0] qmLen; logic [STW-1:0] qmStats;
  logic refValid; logic [HW-1:0] refHandle; logic [FW-1:0] refCount;
  logic freeValid; logic [HW-1:0] freeHandle;
  logic cfgWr = 0; logic [SW-1:0] cfgSlice = '0; logic [CW-1:0] cfgMax = '0;
  logic [SW-1:0] monSlice = '0; logic [CW-1:0] monCur, monOver;

  mcast_copy_engine #(.HANDLE_W(HW), .LEN_W(LW), .SLICE_W(SW), .IDX_W(IW),
    .STATS_W(STW), .CNT_W(CW), .FAN_W(FW)) dut (.*);

  logic [RTW-1:0] rtMem [64];
  always @(posedge clk) if (rtRd) rtData <= rtMem[rtAddr];
  always @(posedge clk) if (hdrTake) hdrHandle <= hdrHandle + 1'b1;

  typedef struct {
    int kind; int port; logic [HW-1:0] handle, payload; logic chained;
    logic [QIDW-QMW-1:0] queue; logic [LW-1:0] len; logic [STW-1:0] stats;
    logic [FW-1:0] count; string req;
  } expItem_t;
  expItem_t expQ[$];

  int checks = 0, fails = 0;
  logic [CW-1:0] mMax [16], mCur [16], mOver [16];
  logic [HW-1:0] expHdr = 24'h100;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected event per observed output event
  always @(negedge clk) begin
    if (rstN && (|qmValid || refValid || freeValid)) begin
      if (expQ.size() == 0) begin
        chk(0, "R3", "unexpected output event", {qmValid, refValid, freeValid}, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.kind == 0) begin
          chk(qmValid == NQ'(1 << e.port), e.req, "qmValid port", qmValid, 1 << e.port);
          chk(qmHandle == e.handle && qmQueue == e.queue && qmLen == e.len &&
              qmStats == e.stats, e.req, "queue request fields",
              {qmHandle, qmQueue}, {e.handle, e.queue});
          chk(qmPayload == e.payload && qmChained == e.chained, e.req,
              "payload/chain", {qmPayload, qmChained}, {e.payload, e.chained});
        end else if (e.kind == 1) begin
          chk(refValid && refHandle == e.handle && refCount == e.count, e.req,
              "reference write", {refValid, refHandle, refCount}, {1'b1, e.handle, e.count});
        end else begin
          chk(freeValid && freeHandle == e.handle, e.req, "free event",
              {freeValid, freeHandle}, {1'b1, e.handle});
        end
      end
    end
  end

  task automatic pushQm(input logic [RTW-1:0] ent, input logic [HW-1:0] h,
                        input logic [HW-1:0] p, input bit ch, input logic [LW-1:0] len,
                        input logic [STW-1:0] st, input string req);
    expItem_t e;
    e.kind = 0; e.port = int'(ent[19:18]); e.queue = ent[17:0];
    e.handle = h; e.payload = p; e.chained = ch; e.len = len; e.stats = st;
    e.count = '0; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic pushOther(input int kind, input logic [HW-1:0] h,
                           input logic [FW-1:0] cnt, input string req);
    expItem_t e;
    e.kind = kind; e.port = 0; e.handle = h; e.payload = '0; e.chained = 0;
    e.queue = '0; e.len = '0; e.stats = '0; e.count = cnt; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic configure(input int s, input int mx);
    @(negedge clk);
    cfgWr = 1; cfgSlice = SW'(s); cfgMax = CW'(mx);
    @(negedge clk);
    cfgWr = 0;
    mMax[s] = CW'(mx); mCur[s] = '0; mOver[s] = '0;
  endtask

  task automatic checkCounts(input int s, input string req);
    monSlice = SW'(s);
    #1;
    chk(monCur == mCur[s], req, "current count", monCur, mCur[s]);
    chk(monOver == mOver[s], req, "over-limit count", monOver, mOver[s]);
  endtask

  // driver: computes expectations, then applies one descriptor
  task automatic send(input int s, input int idx, input bit mc,
                      input logic [HW-1:0] h, input logic [LW-1:0] len,
                      input logic [STW-1:0] st);
    logic [RTW-1:0] ent;
    logic [FW-1:0] fan;
    ent = rtMem[idx];
    fan = ent[23:20];
    if (!mc) begin
      if (mCur[s] < mMax[s]) begin
        mCur[s]++; pushQm(ent, h, '0, 0, len, st, "R3");
      end else begin
        mOver[s]++; pushOther(2, h, '0, "R5");
      end
    end else if (fan == 0) begin
      pushOther(2, h, '0, "R9");
    end else if (!(mCur[s] < mMax[s])) begin
      mOver[s]++; pushOther(2, h, '0, "R5");
    end else begin
      mCur[s]++;
      if (len != 0) pushOther(1, h, fan, "R6");
      else          pushOther(2, h, '0, "R8");
      for (int k = 1; k <= int'(fan); k++) begin
        pushQm(rtMem[idx + k], expHdr, h, len != 0, len, st, "R7");
        expHdr++;
      end
    end
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1; inSlice = SW'(s); inResultIdx = {mc, IW'(idx)};
    inHandle = h; inLen = len; inStats = st;
    #1;
    chk(rtRd && rtAddr == IW'(idx), "R2", "table read address", {rtRd, rtAddr}, {1'b1, IW'(idx)});
    @(negedge clk);
    inValid = 0;
    chk(!inReady, "R10", "inReady during processing", inReady, 0);
    while (!inReady) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R10", "pending expected events", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) rtMem[i] = '0;
    for (int i = 0; i < 16; i++) begin mMax[i] = '0; mCur[i] = '0; mOver[i] = '0; end
    rtMem[5]  = {4'd0, 2'd2, 3'd5, 15'd77};
    rtMem[6]  = {4'd0, 2'd1, 3'd1, 15'd9};
    rtMem[10] = {4'd3, 20'd0};
    rtMem[11] = {4'd0, 2'd0, 3'd2, 15'd100};
    rtMem[12] = {4'd0, 2'd3, 3'd7, 15'd200};
    rtMem[13] = {4'd0, 2'd1, 3'd4, 15'd300};
    rtMem[20] = {4'd0, 20'd5};
    rtMem[30] = {4'd15, 20'd0};
    for (int k = 1; k <= 15; k++) rtMem[30 + k] = {4'd0, 2'(k), 3'(k), 15'(k * 11)};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(inReady == 1, "R1", "inReady after reset", inReady, 1);
    chk(qmValid == 0 && !refValid && !freeValid, "R1", "no output after reset",
        {qmValid, refValid, freeValid}, 0);
    rstN = 1;
    @(negedge clk);
    checkCounts(3, "R1");

    configure(1, 2); configure(2, 10); configure(3, 0);

    // R3 / R4 unicast within budget, R5 over budget
    send(1, 5, 0, 24'hA01, 16'd64, 16'h11);
    checkCounts(1, "R4");
    send(1, 6, 0, 24'hA02, 16'd80, 16'h12);
    send(1, 5, 0, 24'hA03, 16'd90, 16'h13);
    checkCounts(1, "R5");

    // R6 / R7 multicast with payload
    send(2, 10, 1, 24'hB01, 16'd100, 16'h21);
    checkCounts(2, "R6");
    // R8 multicast with empty payload
    send(2, 10, 1, 24'hB02, 16'd0, 16'h22);
    // R9 zero fanout
    send(2, 20, 1, 24'hB03, 16'd40, 16'h23);
    checkCounts(2, "R9");
    // R5 multicast refused by budget 0
    send(3, 10, 1, 24'hC01, 16'd50, 16'h31);
    checkCounts(3, "R5");
    // R12 full fanout
    send(2, 30, 1, 24'hD01, 16'd256, 16'h41);
    checkCounts(2, "R12");
    // R11 reconfiguration clears counts, then accepts again
    configure(1, 1);
    checkCounts(1, "R11");
    send(1, 6, 0, 24'hE01, 16'd70, 16'h51);
    send(1, 6, 0, 24'hE02, 16'd70, 16'h52);
    checkCounts(1, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule